// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block commits a trap for a hart that runs at user, supervisor or machine privilege. The pipeline raises a one-cycle trap strobe and presents the trap with it: the cause code, a flag that separates interrupts from synchronous exceptions, the PC of the trapping instruction, the faulting address and the raw instruction bits. On that clock edge the unit does four things. It picks the handling level from the two delegation masks. It pushes the interrupt-enable and privilege stack of that level. It writes the level's cause, exception-PC and trap-value registers. It switches privilege. In the next cycle it emits a one-cycle redirect pulse with the handler address.

The delegation masks and the two trap-vector registers come in as inputs from the surrounding CSR file. The unit holds the state that a trap modifies and drives it out continuously for readback. That state is the privilege level, the two enable/previous-enable pairs, the previous-privilege fields, and the cause, EPC and trap-value registers of both levels. A small write port lets the CSR and return logic elsewhere in the core load the privilege level and the two enable bits.

Top module: `trap_entry_unit`

## Requirements
- R1: Reset leaves privilege at machine (encoding 3). It clears every enable, previous-enable, previous-privilege, cause, EPC and trap-value field, and holds the redirect pulse low.
- R2: A trap is handled at supervisor (encoding 1) only when all three hold: the current privilege is user (0) or supervisor (1), the effective cause is below XLEN, and that cause's bit is set in the interrupt delegation mask (for interrupts) or the exception delegation mask (for exceptions). Every other trap is handled at machine (3).
- R3: On supervisor entry, the supervisor previous-enable takes the old supervisor enable. The supervisor previous-privilege bit takes bit 0 of the old privilege. The supervisor enable clears. The machine fields stay unchanged.
- R4: On machine entry, the machine previous-enable takes the old machine enable. The 2-bit machine previous-privilege takes the old privilege. The machine enable clears. The supervisor fields stay unchanged.
- R5: The cause register of the handling level receives the effective cause code, zero-extended, with bit XLEN-1 set for interrupts and clear for exceptions.
- R6: The EPC register of the handling level receives the trap PC, and the privilege becomes the handling level.
- R7: The redirect PC is the selected trap-vector register with bits 1:0 forced to zero. When bits 1:0 of that register equal 1 and the trap is an interrupt, 4 times the cause is added. The mode values 0, 2 and 3 add nothing.
- R8: For exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15, the trap-value register receives the faulting address. For exception cause 2, it receives the instruction bits. For every other exception and for every interrupt, it receives zero.
- R9: An exception with input cause 8 is an environment call. Its effective cause depends on the current privilege: 8 from user, 9 from supervisor, 11 from machine. Delegation and the cause register both use the effective cause.
- R10: A write-port strobe loads the privilege and both enable bits on the next edge. A written privilege of 2 is stored as user (0). When the write strobe and the trap strobe come in the same cycle, the trap wins and the write is dropped.
- R11: The redirect pulse is high in exactly the cycles that follow a cycle with the trap strobe high. The redirect PC and all updated registers are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_i | input | 1 | Trap commit strobe |
| irq_i | input | 1 | 1 = interrupt, 0 = exception |
| cause_i | input | CAUSE_W | Raw cause code |
| pc_i | input | XLEN | PC of the trapping instruction |
| badaddr_i | input | XLEN | Faulting address |
| insn_i | input | XLEN | Trapping instruction bits |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| mtvec_i | input | XLEN | Machine trap-vector (base and mode) |
| stvec_i | input | XLEN | Supervisor trap-vector (base and mode) |
| wr_i | input | 1 | State write strobe |
| wr_priv_i | input | 2 | Privilege to load |
| wr_sie_i | input | 1 | Supervisor enable to load |
| wr_mie_i | input | 1 | Machine enable to load |
| redirect_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | XLEN | Handler address |
| priv_o | output | 2 | Current privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor EPC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine EPC |
| mtval_o | output | XLEN | Machine trap value |

## Verification
A wrong privilege or enable value never stays hidden. It shows in the same cycle on priv_o or the enable outputs. At the next trap it also spreads into the wrong level's registers, the previous-privilege fields and a remapped environment-call cause. A bad delegation or vector decision shows one cycle after the strobe, as a wrong handler address together with registers written at the wrong level. The vectors are therefore chosen so that each privilege, each trap-value class and each vector mode leaves its own signature in that first cycle.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   localparam logic [1:0] PRIV_U    = 2'd0;
   localparam logic [1:0] PRIV_S    = 2'd1;
   localparam logic [1:0] PRIV_RSVD = 2'd2;
   localparam logic [1:0] PRIV_M    = 2'd3;

   localparam int unsigned EC_CALL_U = 8;
   localparam int unsigned EC_CALL_S = 9;
   localparam int unsigned EC_CALL_M = 11;
   localparam int unsigned EC_ILLEGAL = 2;

   typedef enum logic [1:0] {
      TV_ZERO = 2'd0,
      TV_ADDR = 2'd1,
      TV_INSN = 2'd2
   } tval_src_e;

   localparam logic [1:0] TVEC_VECTORED = 2'b01;

endpackage

// File: rtl/trap_cause_map.sv
module trap_cause_map
   import trap_entry_pkg::*;
#(
   parameter int unsigned CAUSE_W = 6
) (
   input  logic               irq_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [1:0]         priv_i,
   output logic [CAUSE_W-1:0] cause_o,
   output tval_src_e          tval_src_o
);

   logic is_ecall;

   assign is_ecall = !irq_i && (cause_i == CAUSE_W'(EC_CALL_U));

   // environment calls carry the caller's privilege in the code
   always_comb begin
      cause_o = cause_i;
      if (is_ecall) begin
         unique case (priv_i)
            PRIV_M:  cause_o = CAUSE_W'(EC_CALL_M);
            PRIV_S:  cause_o = CAUSE_W'(EC_CALL_S);
            default: cause_o = CAUSE_W'(EC_CALL_U);
         endcase
      end
   end

   // trap-value class by cause
   always_comb begin
      tval_src_o = TV_ZERO;
      if (!irq_i) begin
         case (cause_i)
            CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(4), CAUSE_W'(5),
            CAUSE_W'(6), CAUSE_W'(7), CAUSE_W'(12), CAUSE_W'(13),
            CAUSE_W'(15):            tval_src_o = TV_ADDR;
            CAUSE_W'(EC_ILLEGAL):    tval_src_o = TV_INSN;
            default:                 tval_src_o = TV_ZERO;
         endcase
      end
   end

endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
   import trap_entry_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 6
) (
   input  logic               irq_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [1:0]         priv_i,
   input  logic [XLEN-1:0]    medeleg_i,
   input  logic [XLEN-1:0]    mideleg_i,
   output logic               to_super_o
);

   localparam int unsigned IDX_W = $clog2(XLEN);

   logic [XLEN-1:0] mask;
   logic            in_range;
   logic            mask_bit;
   logic            low_priv;

   assign mask     = irq_i ? mideleg_i : medeleg_i;
   assign mask_bit = mask[cause_i[IDX_W-1:0]];
   assign low_priv = (priv_i == PRIV_U) || (priv_i == PRIV_S);

   generate
      if (CAUSE_W > IDX_W) begin : g_range_chk
         assign in_range = (cause_i[CAUSE_W-1:IDX_W] == '0);
      end else begin : g_range_all
         assign in_range = 1'b1;
      end
   endgenerate

   assign to_super_o = low_priv && in_range && mask_bit;

endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc
   import trap_entry_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 6,
   parameter bit          VECTORED_EN = 1'b1
) (
   input  logic [XLEN-1:0]    tvec_i,
   input  logic               irq_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic [XLEN-1:0]    target_o
);

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   assign base = {tvec_i[XLEN-1:2], 2'b00};

   generate
      if (VECTORED_EN) begin : g_vectored
         logic [XLEN-1:0] scaled;
         assign scaled = {{(XLEN-CAUSE_W-2){1'b0}}, cause_i, 2'b00};
         assign offset = (irq_i && (tvec_i[1:0] == TVEC_VECTORED)) ? scaled : '0;
      end else begin : g_direct
         assign offset = '0;
      end
   endgenerate

   assign target_o = base + offset;

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
   import trap_entry_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit_i,
   input  logic               to_super_i,
   input  logic               irq_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [XLEN-1:0]    epc_i,
   input  logic [XLEN-1:0]    tval_i,
   input  logic [XLEN-1:0]    target_i,
   input  logic               wr_i,
   input  logic [1:0]         wr_priv_i,
   input  logic               wr_sie_i,
   input  logic               wr_mie_i,
   output logic               redirect_o,
   output logic [XLEN-1:0]    redirect_pc_o,
   output logic [1:0]         priv_o,
   output logic               sie_o,
   output logic               spie_o,
   output logic               spp_o,
   output logic               mie_o,
   output logic               mpie_o,
   output logic [1:0]         mpp_o,
   output logic [XLEN-1:0]    scause_o,
   output logic [XLEN-1:0]    sepc_o,
   output logic [XLEN-1:0]    stval_o,
   output logic [XLEN-1:0]    mcause_o,
   output logic [XLEN-1:0]    mepc_o,
   output logic [XLEN-1:0]    mtval_o
);

   localparam int unsigned PAD_W = XLEN - 1 - CAUSE_W;

   logic [XLEN-1:0] cause_word;
   logic [1:0]      wr_priv_legal;

   assign cause_word    = {irq_i, {PAD_W{1'b0}}, cause_i};
   assign wr_priv_legal = (wr_priv_i == PRIV_RSVD) ? PRIV_U : wr_priv_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_o    <= 1'b0;
         redirect_pc_o <= '0;
      end else begin
         redirect_o <= commit_i;
         if (commit_i) begin
            redirect_pc_o <= target_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_o   <= PRIV_M;
         sie_o    <= 1'b0;
         spie_o   <= 1'b0;
         spp_o    <= 1'b0;
         mie_o    <= 1'b0;
         mpie_o   <= 1'b0;
         mpp_o    <= PRIV_U;
         scause_o <= '0;
         sepc_o   <= '0;
         stval_o  <= '0;
         mcause_o <= '0;
         mepc_o   <= '0;
         mtval_o  <= '0;
      end else if (commit_i) begin
         if (to_super_i) begin
            spie_o   <= sie_o;
            spp_o    <= priv_o[0];
            sie_o    <= 1'b0;
            scause_o <= cause_word;
            sepc_o   <= epc_i;
            stval_o  <= tval_i;
            priv_o   <= PRIV_S;
         end else begin
            mpie_o   <= mie_o;
            mpp_o    <= priv_o;
            mie_o    <= 1'b0;
            mcause_o <= cause_word;
            mepc_o   <= epc_i;
            mtval_o  <= tval_i;
            priv_o   <= PRIV_M;
         end
      end else if (wr_i) begin
         priv_o <= wr_priv_legal;
         sie_o  <= wr_sie_i;
         mie_o  <= wr_mie_i;
      end
   end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_entry_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 6,
   parameter bit          VECTORED_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_i,
   input  logic               irq_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [XLEN-1:0]    badaddr_i,
   input  logic [XLEN-1:0]    insn_i,
   input  logic [XLEN-1:0]    medeleg_i,
   input  logic [XLEN-1:0]    mideleg_i,
   input  logic [XLEN-1:0]    mtvec_i,
   input  logic [XLEN-1:0]    stvec_i,
   input  logic               wr_i,
   input  logic [1:0]         wr_priv_i,
   input  logic               wr_sie_i,
   input  logic               wr_mie_i,
   output logic               redirect_o,
   output logic [XLEN-1:0]    redirect_pc_o,
   output logic [1:0]         priv_o,
   output logic               sie_o,
   output logic               spie_o,
   output logic               spp_o,
   output logic               mie_o,
   output logic               mpie_o,
   output logic [1:0]         mpp_o,
   output logic [XLEN-1:0]    scause_o,
   output logic [XLEN-1:0]    sepc_o,
   output logic [XLEN-1:0]    stval_o,
   output logic [XLEN-1:0]    mcause_o,
   output logic [XLEN-1:0]    mepc_o,
   output logic [XLEN-1:0]    mtval_o
);

   localparam int unsigned IDX_W = $clog2(XLEN);

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("trap_entry_unit: XLEN must be 32 or 64");
      end
      if (CAUSE_W < IDX_W) begin : g_bad_cause_narrow
         $error("trap_entry_unit: CAUSE_W must index every delegation bit");
      end
      if (CAUSE_W + 3 > XLEN) begin : g_bad_cause_wide
         $error("trap_entry_unit: CAUSE_W too wide for cause and vector offset");
      end
   endgenerate

   logic [CAUSE_W-1:0] eff_cause;
   tval_src_e          tval_src;
   logic               to_super;
   logic [XLEN-1:0]    tvec_sel;
   logic [XLEN-1:0]    target_pc;
   logic [XLEN-1:0]    tval_val;

   trap_cause_map #(
      .CAUSE_W (CAUSE_W)
   ) u_map (
      .irq_i      (irq_i),
      .cause_i    (cause_i),
      .priv_i     (priv_o),
      .cause_o    (eff_cause),
      .tval_src_o (tval_src)
   );

   trap_deleg_sel #(
      .XLEN    (XLEN),
      .CAUSE_W (CAUSE_W)
   ) u_deleg (
      .irq_i      (irq_i),
      .cause_i    (eff_cause),
      .priv_i     (priv_o),
      .medeleg_i  (medeleg_i),
      .mideleg_i  (mideleg_i),
      .to_super_o (to_super)
   );

   assign tvec_sel = to_super ? stvec_i : mtvec_i;

   trap_vec_calc #(
      .XLEN        (XLEN),
      .CAUSE_W     (CAUSE_W),
      .VECTORED_EN (VECTORED_EN)
   ) u_vec (
      .tvec_i   (tvec_sel),
      .irq_i    (irq_i),
      .cause_i  (eff_cause),
      .target_o (target_pc)
   );

   always_comb begin
      unique case (tval_src)
         TV_ADDR: tval_val = badaddr_i;
         TV_INSN: tval_val = insn_i;
         default: tval_val = '0;
      endcase
   end

   trap_csr_bank #(
      .XLEN    (XLEN),
      .CAUSE_W (CAUSE_W)
   ) u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .commit_i      (trap_i),
      .to_super_i    (to_super),
      .irq_i         (irq_i),
      .cause_i       (eff_cause),
      .epc_i         (pc_i),
      .tval_i        (tval_val),
      .target_i      (target_pc),
      .wr_i          (wr_i),
      .wr_priv_i     (wr_priv_i),
      .wr_sie_i      (wr_sie_i),
      .wr_mie_i      (wr_mie_i),
      .redirect_o    (redirect_o),
      .redirect_pc_o (redirect_pc_o),
      .priv_o        (priv_o),
      .sie_o         (sie_o),
      .spie_o        (spie_o),
      .spp_o         (spp_o),
      .mie_o         (mie_o),
      .mpie_o        (mpie_o),
      .mpp_o         (mpp_o),
      .scause_o      (scause_o),
      .sepc_o        (sepc_o),
      .stval_o       (stval_o),
      .mcause_o      (mcause_o),
      .mepc_o        (mepc_o),
      .mtval_o       (mtval_o)
   );

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trap_i,
   input logic               irq_i,
   input logic [XLEN-1:0]    pc_i,
   input logic               redirect_o,
   input logic [XLEN-1:0]    redirect_pc_o,
   input logic [1:0]         priv_o,
   input logic               sie_o,
   input logic               mie_o,
   input logic [XLEN-1:0]    scause_o,
   input logic [XLEN-1:0]    sepc_o,
   input logic [XLEN-1:0]    mcause_o,
   input logic [XLEN-1:0]    mepc_o
);

   // R11
   redirect_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> redirect_o);

   // R11
   redirect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_i |=> !redirect_o);

   // R6
   epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> ((priv_o == 2'd3) ? (mepc_o == $past(pc_i)) : (sepc_o == $past(pc_i))));

   // R3 and R4
   enable_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> ((priv_o == 2'd3) ? !mie_o : !sie_o));

   // R5
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && irq_i) |=> ((priv_o == 2'd3) ? mcause_o[XLEN-1] : scause_o[XLEN-1]));

   // R2
   machine_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && priv_o == 2'd3) |=> (priv_o == 2'd3));

   // R7
   target_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> (redirect_pc_o[1:0] == 2'b00));

   // R10
   priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      priv_o != 2'd2);

endmodule

bind trap_entry_unit trap_entry_chk #(
   .XLEN    (XLEN),
   .CAUSE_W (CAUSE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .trap_i        (trap_i),
   .irq_i         (irq_i),
   .pc_i          (pc_i),
   .redirect_o    (redirect_o),
   .redirect_pc_o (redirect_pc_o),
   .priv_o        (priv_o),
   .sie_o         (sie_o),
   .mie_o         (mie_o),
   .scause_o      (scause_o),
   .sepc_o        (sepc_o),
   .mcause_o      (mcause_o),
   .mepc_o        (mepc_o)
);

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;

   localparam int XLEN    = 32;
   localparam int CAUSE_W = 6;
   localparam int NVEC    = 13;

   typedef struct packed {
      logic [1:0]  pr;
      logic        irq;
      logic [5:0]  cause;
      logic        to_s;
      logic [31:0] ecause;
      logic [1:0]  tsel;
      logic [31:0] npc;
   } vec_t;

   // pr, irq, cause, to_s, expected cause, tval source (0 zero,1 addr,2 insn), redirect
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 1'b0, 6'd8,  1'b1, 32'h0000_0008, 2'd0, 32'h4000_0200},
      '{2'd1, 1'b0, 6'd8,  1'b0, 32'h0000_0009, 2'd0, 32'h8000_0000},
      '{2'd3, 1'b0, 6'd8,  1'b0, 32'h0000_000B, 2'd0, 32'h8000_0000},
      '{2'd1, 1'b0, 6'd13, 1'b1, 32'h0000_000D, 2'd1, 32'h4000_0200},
      '{2'd3, 1'b0, 6'd13, 1'b0, 32'h0000_000D, 2'd1, 32'h8000_0000},
      '{2'd0, 1'b0, 6'd2,  1'b1, 32'h0000_0002, 2'd2, 32'h4000_0200},
      '{2'd0, 1'b0, 6'd4,  1'b0, 32'h0000_0004, 2'd1, 32'h8000_0000},
      '{2'd1, 1'b1, 6'd5,  1'b1, 32'h8000_0005, 2'd0, 32'h4000_0200},
      '{2'd0, 1'b1, 6'd7,  1'b0, 32'h8000_0007, 2'd0, 32'h8000_001C},
      '{2'd1, 1'b0, 6'd3,  1'b0, 32'h0000_0003, 2'd0, 32'h8000_0000},
      '{2'd0, 1'b1, 6'd1,  1'b1, 32'h8000_0001, 2'd0, 32'h4000_0200},
      '{2'd3, 1'b1, 6'd9,  1'b0, 32'h8000_0009, 2'd0, 32'h8000_0024},
      '{2'd1, 1'b1, 6'd2,  1'b0, 32'h8000_0002, 2'd0, 32'h8000_0008}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               trap_i = 1'b0;
   logic               irq_i = 1'b0;
   logic [CAUSE_W-1:0] cause_i = '0;
   logic [XLEN-1:0]    pc_i = '0;
   logic [XLEN-1:0]    badaddr_i = '0;
   logic [XLEN-1:0]    insn_i = '0;
   logic [XLEN-1:0]    medeleg_i = 32'h0000_2104;
   logic [XLEN-1:0]    mideleg_i = 32'h0000_0022;
   logic [XLEN-1:0]    mtvec_i = 32'h8000_0001;
   logic [XLEN-1:0]    stvec_i = 32'h4000_0203;
   logic               wr_i = 1'b0;
   logic [1:0]         wr_priv_i = '0;
   logic               wr_sie_i = 1'b0;
   logic               wr_mie_i = 1'b0;
   logic               redirect_o;
   logic [XLEN-1:0]    redirect_pc_o;
   logic [1:0]         priv_o;
   logic               sie_o, spie_o, spp_o, mie_o, mpie_o;
   logic [1:0]         mpp_o;
   logic [XLEN-1:0]    scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   trap_entry_unit u_trap_entry_unit (
      .clk, .rst_n, .trap_i, .irq_i, .cause_i, .pc_i, .badaddr_i, .insn_i,
      .medeleg_i, .mideleg_i, .mtvec_i, .stvec_i,
      .wr_i, .wr_priv_i, .wr_sie_i, .wr_mie_i,
      .redirect_o, .redirect_pc_o, .priv_o, .sie_o, .spie_o, .spp_o,
      .mie_o, .mpie_o, .mpp_o, .scause_o, .sepc_o, .stval_o,
      .mcause_o, .mepc_o, .mtval_o
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr_state(input logic [1:0] p, input logic s, input logic m);
      @(negedge clk);
      wr_i = 1'b1; wr_priv_i = p; wr_sie_i = s; wr_mie_i = m;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   // raise strobe for one cycle; returns at the negedge after the commit edge
   task automatic fire(input logic q, input logic [5:0] c, input logic [31:0] pc,
                       input logic [31:0] ba, input logic [31:0] ins);
      @(negedge clk);
      trap_i = 1'b1; irq_i = q; cause_i = c; pc_i = pc; badaddr_i = ba; insn_i = ins;
      @(negedge clk);
      trap_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 priv", priv_o, 2'd3);
      chk("R1 redirect", redirect_o, 1'b0);
      chk("R1 mcause", mcause_o, 0);
      chk("R1 sepc", sepc_o, 0);
      chk("R1 mie", mie_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [31:0] pc, ba, ins, etv;
         pc  = 32'h1000_0000 + 32'(i * 16);
         ba  = 32'hBAD0_0000 | 32'(i);
         ins = 32'h0000_1073 + 32'(i << 12);
         etv = (VECS[i].tsel == 2'd1) ? ba : (VECS[i].tsel == 2'd2) ? ins : 32'h0;
         wr_state(VECS[i].pr, 1'b1, 1'b1);
         fire(VECS[i].irq, VECS[i].cause, pc, ba, ins);
         chk("R11 pulse", redirect_o, 1'b1);
         chk("R7 target", redirect_pc_o, VECS[i].npc);
         if (VECS[i].to_s) begin
            chk("R2 R6 priv", priv_o, 2'd1);
            chk("R5 R9 scause", scause_o, VECS[i].ecause);
            chk("R6 sepc", sepc_o, pc);
            chk("R8 stval", stval_o, etv);
            chk("R3 spp", spp_o, VECS[i].pr[0]);
            chk("R3 spie", spie_o, 1'b1);
            chk("R3 sie", sie_o, 1'b0);
            chk("R3 mie kept", mie_o, 1'b1);
         end else begin
            chk("R2 R6 priv", priv_o, 2'd3);
            chk("R5 R9 mcause", mcause_o, VECS[i].ecause);
            chk("R6 mepc", mepc_o, pc);
            chk("R8 mtval", mtval_o, etv);
            chk("R4 mpp", mpp_o, VECS[i].pr);
            chk("R4 mpie", mpie_o, 1'b1);
            chk("R4 mie", mie_o, 1'b0);
            chk("R4 sie kept", sie_o, 1'b1);
         end
         @(negedge clk);
         chk("R11 pulse end", redirect_o, 1'b0);
      end

      // R10 reserved privilege stored as user
      wr_state(2'd2, 1'b0, 1'b0);
      chk("R10 rsvd priv", priv_o, 2'd0);
      wr_state(2'd1, 1'b1, 1'b0);
      chk("R10 priv load", priv_o, 2'd1);
      chk("R10 sie load", sie_o, 1'b1);

      // R10 trap beats a simultaneous write
      @(negedge clk);
      wr_i = 1'b1; wr_priv_i = 2'd0; wr_sie_i = 1'b0; wr_mie_i = 1'b1;
      trap_i = 1'b1; irq_i = 1'b0; cause_i = 6'd3; pc_i = 32'h2222_0000;
      @(negedge clk);
      wr_i = 1'b0; trap_i = 1'b0;
      chk("R10 trap wins priv", priv_o, 2'd3);
      chk("R10 trap wins mpp", mpp_o, 2'd1);
      chk("R10 trap wins mie", mie_o, 1'b0);

      // R2 cause at or above XLEN never delegates
      medeleg_i = '1;
      wr_state(2'd0, 1'b0, 1'b0);
      fire(1'b0, 6'd40, 32'h3000_0000, 32'h0, 32'h0);
      chk("R2 wide cause priv", priv_o, 2'd3);
      chk("R5 wide cause", mcause_o, 32'd40);
      wr_state(2'd0, 1'b0, 1'b0);
      fire(1'b0, 6'd31, 32'h3000_0010, 32'h0, 32'h0);
      chk("R2 cause 31 priv", priv_o, 2'd1);
      medeleg_i = 32'h0000_2104;

      // R7 vectored supervisor vector: interrupts offset, exceptions not
      stvec_i = 32'h4000_0101;
      wr_state(2'd1, 1'b0, 1'b0);
      fire(1'b1, 6'd5, 32'h3000_0020, 32'h0, 32'h0);
      chk("R7 s vectored irq", redirect_pc_o, 32'h4000_0114);
      wr_state(2'd0, 1'b0, 1'b0);
      fire(1'b0, 6'd2, 32'h3000_0030, 32'h0, 32'hDEAD_0013);
      chk("R7 s vectored exc", redirect_pc_o, 32'h4000_0100);
      chk("R8 illegal tval", stval_o, 32'hDEAD_0013);

      // R7 machine vectored interrupt 11
      fire(1'b1, 6'd11, 32'h3000_0040, 32'h0, 32'h0);
      chk("R7 m vectored irq", redirect_pc_o, 32'h8000_002C);

      // R11 back-to-back strobes
      @(negedge clk);
      trap_i = 1'b1; irq_i = 1'b0; cause_i = 6'd3; pc_i = 32'h5000_0000;
      @(negedge clk);
      pc_i = 32'h5000_0004;
      chk("R11 b2b first", redirect_o, 1'b1);
      chk("R6 b2b epc A", mepc_o, 32'h5000_0000);
      @(negedge clk);
      trap_i = 1'b0;
      chk("R11 b2b second", redirect_o, 1'b1);
      chk("R6 b2b epc B", mepc_o, 32'h5000_0004);
      @(negedge clk);
      chk("R11 b2b end", redirect_o, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule